// File: doc/BRIEF.md
# Store-to-Load Offset Check Queue

This block holds memory operations in program order and decides, for each load, whether it may run ahead of the stores queued before it. Each entry carries only its page offset: the low 12 address bits, which are the same before and after translation. The check can therefore start while the page number is still being looked up. The oldest entry that has not been checked yet is processed once a translated page number for it is presented. A load is compared, at 8-byte granularity, against every older store still held in the queue. The result says whether the load may bypass those stores, whether it takes its data from one of them, or whether it has to be replayed.

A store stays in the queue as a forwarding source after its own check, until it reaches the head and is retired. A checked load at the head leaves the queue on its own. A flush empties the queue.

Enqueue and result are valid/ready streams. An item moves on a clock edge where valid and ready are both high. A source holds valid and the item's fields steady until that edge. `enq_ready` depends only on occupancy and flush, never on `enq_valid`. `res_valid` needs a waiting entry and `xlat_valid`. While `res_ready` is low the same entry stays on the output. The translation input, retire and flush are plain control pins.

Top module: `mem_order_q`

## Requirements
- R1: The queue holds at most DEPTH (12) entries. `enq_ready` is low when it is full and during flush, and an enqueue offered while `enq_ready` is low is not taken.
- R2: Results appear in enqueue order, one per entry, only while `xlat_valid` is high. `res_pa` is `xlat_ppn` concatenated above the entry's 12-bit offset, and `res_age` is the entry's age.
- R3: A load whose offset bits [11:3] match no older store still held reports kind 0 (bypass) with `res_data` zero.
- R4: A load that matches an older store in bits [11:3], with equal size code and equal bits [2:0], reports kind 1 (forward) and `res_data` equal to that store's data.
- R5: When several older stores match, the youngest of them decides the kind and supplies the data.
- R6: A matching store whose size code or offset bits [2:0] differ from the load's gives kind 2 (replay). The size code gives 2^code bytes.
- R7: A store reports kind 3 and remains a forwarding source until it is at the head, already checked, and `st_retire` is high. `st_retire` has no effect in any other case.
- R8: A store enqueued after a load never affects that load's result.
- R9: `flush` empties the queue. In the next cycle `res_valid` is low, `enq_ready` is high, and no earlier store forwards.
- R10: While `res_valid` is high and `res_ready` is low, the same entry, with the same age, stays on the output as long as `xlat_valid` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empties all entries |
| enq_valid | input | 1 | Enqueue offer |
| enq_ready | output | 1 | Enqueue can be taken |
| enq_is_store | input | 1 | 1 for a store, 0 for a load |
| enq_age | input | AGE_W | Age tag of the operation |
| enq_off | input | 12 | Page offset of the address |
| enq_size | input | 2 | Size code, 2^code bytes |
| enq_data | input | DATA_W | Store data (unused for loads) |
| xlat_valid | input | 1 | Page number for the oldest unchecked entry is present |
| xlat_ppn | input | PA_W-12 | Translated page number |
| st_retire | input | 1 | Retire the checked store at the head |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken |
| res_kind | output | 2 | 0 bypass, 1 forward, 2 replay, 3 store |
| res_age | output | AGE_W | Age tag of the checked entry |
| res_pa | output | PA_W | Physical address of the checked entry |
| res_data | output | DATA_W | Forwarded data, zero otherwise |

## Verification
The assertions assume that `st_retire` is used only to release stores and that a flush is a plain one-cycle request. They do not assume that `xlat_ppn` stays fixed: the hold check on a stalled result only requires the age to stay the same while `xlat_valid` stays high. The stimulus changes inputs only after a rising edge and keeps the page number constant. It never holds more stores than the queue can take between drains. It raises `st_retire` on purpose while the head store is still unchecked, so the block's rejection of a retire in that state is covered too.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;
  localparam int unsigned PAGE_OFF_W = 12;
  localparam int unsigned GRAN_LSB   = 3;
  localparam int unsigned SIZE_W     = 2;

  typedef enum logic [1:0] {
    RES_PASS   = 2'd0,
    RES_FWD    = 2'd1,
    RES_REPLAY = 2'd2,
    RES_STORE  = 2'd3
  } res_kind_e;
endpackage

// File: rtl/moq_ring.sv
module moq_ring #(
  parameter int unsigned DEPTH = 12,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             enq_fire,
  input  logic             chk_fire,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W-1:0] chk_idx,
  output logic [CNT_W-1:0] done_cnt,
  output logic             full,
  output logic             chk_avail,
  output logic             head_done
);
  logic [IDX_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] done_q;

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] b,
                                                 input logic [CNT_W-1:0] o);
    int unsigned s;
    s = int'(b) + int'(o);
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  assign head_idx  = head_q;
  assign tail_idx  = wrap_add(head_q, cnt_q);
  assign chk_idx   = wrap_add(head_q, done_q);
  assign done_cnt  = done_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign chk_avail = (done_q < cnt_q);
  assign head_done = (done_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      done_q <= '0;
    end else if (flush) begin
      head_q <= '0;
      cnt_q  <= '0;
      done_q <= '0;
    end else begin
      if (pop) head_q <= wrap_add(head_q, CNT_W'(1));
      cnt_q  <= cnt_q + CNT_W'(enq_fire) - CNT_W'(pop);
      done_q <= done_q + CNT_W'(chk_fire) - CNT_W'(pop);
    end
  end

  // R1: occupancy never exceeds the queue depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R2: the check pointer never passes the tail
  a_r2_check_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_q <= cnt_q);

  // R7: only an entry already checked can leave the head
  a_r7_pop_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (done_q != '0));
endmodule

// File: rtl/moq_fwd_match.sv
module moq_fwd_match #(
  parameter int unsigned DEPTH    = 12,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned SIZE_W   = 2,
  parameter int unsigned GRAN_LSB = 3,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [CNT_W-1:0]  older_cnt,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              st_q   [DEPTH],
  input  logic [OFF_W-1:0]  off_q  [DEPTH],
  input  logic [SIZE_W-1:0] size_q [DEPTH],
  input  logic [DATA_W-1:0] data_q [DEPTH],
  output logic              hit,
  output logic              exact,
  output logic [DATA_W-1:0] fwd_data
);
  logic [IDX_W-1:0] best;

  // Scan from oldest to youngest; a later match overwrites, so the
  // youngest matching older store wins.
  always_comb begin
    hit  = 1'b0;
    best = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int unsigned s;
      logic [IDX_W-1:0] idx;
      s = int'(head_idx) + i;
      if (s >= DEPTH) s = s - DEPTH;
      idx = IDX_W'(s);
      if ((CNT_W'(i) < older_cnt) && st_q[idx] &&
          (off_q[idx][OFF_W-1:GRAN_LSB] == ld_off[OFF_W-1:GRAN_LSB])) begin
        hit  = 1'b1;
        best = idx;
      end
    end
  end

  assign exact    = hit && (size_q[best] == ld_size) &&
                    (off_q[best][GRAN_LSB-1:0] == ld_off[GRAN_LSB-1:0]);
  assign fwd_data = data_q[best];
endmodule

// File: rtl/mem_order_q.sv
module mem_order_q
  import mem_order_pkg::*;
#(
  parameter int unsigned DEPTH  = 12,
  parameter int unsigned AGE_W  = 6,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned PA_W   = 40,
  localparam int unsigned PPN_W = PA_W - PAGE_OFF_W,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  enq_valid,
  output logic                  enq_ready,
  input  logic                  enq_is_store,
  input  logic [AGE_W-1:0]      enq_age,
  input  logic [PAGE_OFF_W-1:0] enq_off,
  input  logic [SIZE_W-1:0]     enq_size,
  input  logic [DATA_W-1:0]     enq_data,
  input  logic                  xlat_valid,
  input  logic [PPN_W-1:0]      xlat_ppn,
  input  logic                  st_retire,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [1:0]            res_kind,
  output logic [AGE_W-1:0]      res_age,
  output logic [PA_W-1:0]       res_pa,
  output logic [DATA_W-1:0]     res_data
);
  logic                  ent_st   [DEPTH];
  logic [AGE_W-1:0]      ent_age  [DEPTH];
  logic [PAGE_OFF_W-1:0] ent_off  [DEPTH];
  logic [SIZE_W-1:0]     ent_size [DEPTH];
  logic [DATA_W-1:0]     ent_data [DEPTH];

  logic [IDX_W-1:0] head_idx, tail_idx, chk_idx;
  logic [CNT_W-1:0] done_cnt;
  logic             full, chk_avail, head_done;
  logic             enq_fire, chk_fire, pop;
  logic             hit, exact;
  logic [DATA_W-1:0] fwd_data;
  res_kind_e        kind;

  moq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .enq_fire  (enq_fire),
    .chk_fire  (chk_fire),
    .pop       (pop),
    .head_idx  (head_idx),
    .tail_idx  (tail_idx),
    .chk_idx   (chk_idx),
    .done_cnt  (done_cnt),
    .full      (full),
    .chk_avail (chk_avail),
    .head_done (head_done)
  );

  moq_fwd_match #(
    .DEPTH    (DEPTH),
    .DATA_W   (DATA_W),
    .OFF_W    (PAGE_OFF_W),
    .SIZE_W   (SIZE_W),
    .GRAN_LSB (GRAN_LSB)
  ) u_match (
    .head_idx  (head_idx),
    .older_cnt (done_cnt),
    .ld_off    (ent_off[chk_idx]),
    .ld_size   (ent_size[chk_idx]),
    .st_q      (ent_st),
    .off_q     (ent_off),
    .size_q    (ent_size),
    .data_q    (ent_data),
    .hit       (hit),
    .exact     (exact),
    .fwd_data  (fwd_data)
  );

  assign enq_ready = !full && !flush;
  assign enq_fire  = enq_valid && enq_ready;

  always_ff @(posedge clk) begin
    if (enq_fire) begin
      ent_st[tail_idx]   <= enq_is_store;
      ent_age[tail_idx]  <= enq_age;
      ent_off[tail_idx]  <= enq_off;
      ent_size[tail_idx] <= enq_size;
      ent_data[tail_idx] <= enq_data;
    end
  end

  always_comb begin
    if (ent_st[chk_idx])  kind = RES_STORE;
    else if (!hit)        kind = RES_PASS;
    else if (exact)       kind = RES_FWD;
    else                  kind = RES_REPLAY;
  end

  assign res_valid = chk_avail && xlat_valid && !flush;
  assign res_kind  = kind;
  assign res_age   = ent_age[chk_idx];
  assign res_pa    = {xlat_ppn, ent_off[chk_idx]};
  assign res_data  = (kind == RES_FWD) ? fwd_data : '0;
  assign chk_fire  = res_valid && res_ready;

  // Loads leave as soon as they are checked; stores wait for retire.
  assign pop = head_done && !flush && (!ent_st[head_idx] || st_retire);

  // R10: a stalled result keeps its identity while translation holds
  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !flush) |=>
      (!xlat_valid || (res_valid && $stable(res_age))));

  // R9: after a flush nothing is offered and enqueue is open
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!res_valid && enq_ready));
endmodule

// File: tb/mem_order_q_bench.sv
module mem_order_q_bench;
  import mem_order_pkg::*;

  localparam int unsigned DEPTH  = 12;
  localparam int unsigned AGE_W  = 6;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned PA_W   = 40;
  localparam int unsigned PPN_W  = PA_W - PAGE_OFF_W;
  localparam logic [PPN_W-1:0] PPN = PPN_W'(28'h5A5A5A5);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic enq_valid = 1'b0;
  logic enq_ready;
  logic enq_is_store = 1'b0;
  logic [AGE_W-1:0] enq_age = '0;
  logic [PAGE_OFF_W-1:0] enq_off = '0;
  logic [SIZE_W-1:0] enq_size = '0;
  logic [DATA_W-1:0] enq_data = '0;
  logic xlat_valid = 1'b0;
  logic [PPN_W-1:0] xlat_ppn;
  logic st_retire = 1'b0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [1:0] res_kind;
  logic [AGE_W-1:0] res_age;
  logic [PA_W-1:0] res_pa;
  logic [DATA_W-1:0] res_data;

  assign xlat_ppn = PPN;

  always #2 clk = ~clk;

  mem_order_q u_mem_order_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_is_store(enq_is_store),
    .enq_age(enq_age), .enq_off(enq_off), .enq_size(enq_size), .enq_data(enq_data),
    .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn), .st_retire(st_retire),
    .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind),
    .res_age(res_age), .res_pa(res_pa), .res_data(res_data)
  );

  typedef struct {
    logic [1:0]        kind;
    logic [AGE_W-1:0]  age;
    logic [PA_W-1:0]   pa;
    logic [DATA_W-1:0] data;
    string             req;
  } exp_t;

  typedef struct {
    logic [PAGE_OFF_W-1:0] off;
    logic [SIZE_W-1:0]     size;
    logic [DATA_W-1:0]     data;
  } st_t;

  exp_t exp_q[$];
  st_t  live_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  logic [AGE_W-1:0] age_ctr = '0;
  bit   expect_on = 1'b1;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Driver: computes the expected result and pushes it, then offers the op.
  task automatic enq(input bit is_st, input logic [11:0] off,
                     input logic [1:0] size, input logic [63:0] data,
                     input string req);
    exp_t e;
    bit r;
    e.age = age_ctr;
    e.pa  = {PPN, off};
    e.req = req;
    e.data = '0;
    if (is_st) begin
      st_t s;
      e.kind = 2'd3;
      s.off = off; s.size = size; s.data = data;
      if (expect_on) live_q.push_back(s);
    end else begin
      e.kind = 2'd0;
      foreach (live_q[k]) begin
        if (live_q[k].off[11:3] == off[11:3]) begin
          if (live_q[k].size == size && live_q[k].off[2:0] == off[2:0]) begin
            e.kind = 2'd1; e.data = live_q[k].data;
          end else begin
            e.kind = 2'd2; e.data = '0;
          end
        end
      end
    end
    if (expect_on) exp_q.push_back(e);
    enq_valid = 1'b1; enq_is_store = is_st; enq_off = off;
    enq_size = size; enq_data = data; enq_age = age_ctr;
    forever begin
      @(negedge clk); r = enq_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    enq_valid = 1'b0;
    age_ctr = age_ctr + 1'b1;
  endtask

  task automatic wait_empty();
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R2", "all results delivered", exp_q.size(), 0);
  endtask

  task automatic drain();
    wait_empty();
    st_retire = 1'b1;
    repeat (2 * DEPTH + 2) @(posedge clk);
    #1 st_retire = 1'b0;
    live_q.delete();
  endtask

  // Monitor: pops the scoreboard on each accepted result.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected result age", res_age, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_kind == e.kind, e.req, "kind", res_kind, e.kind);
        check(res_age == e.age, "R2", "age order", res_age, e.age);
        check(res_pa == e.pa, "R2", "physical address", res_pa, e.pa);
        check(res_data == e.data, e.req, "data", res_data, e.data);
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(enq_ready == 1'b1, "R1", "reset enq_ready", enq_ready, 1);
    check(res_valid == 1'b0, "R2", "reset res_valid", res_valid, 0);
    @(posedge clk); #1;
    xlat_valid = 1'b1; res_ready = 1'b1;

    // R3 R4 R5 R6: bypass, forward, replay and youngest-match selection
    enq(1, 12'h100, 2'd3, 64'hAAAA_0000_1111_2222, "R7");
    enq(0, 12'h100, 2'd3, '0, "R4");
    enq(0, 12'h200, 2'd3, '0, "R3");
    enq(1, 12'h100, 2'd3, 64'hBBBB_3333_4444_5555, "R7");
    enq(0, 12'h104, 2'd2, '0, "R6");
    enq(0, 12'h100, 2'd3, '0, "R5");
    enq(0, 12'h1F8, 2'd3, '0, "R3");
    drain();

    // R8: younger store ignored; R6 same size, different byte offset
    enq(0, 12'h300, 2'd3, '0, "R8");
    enq(1, 12'h300, 2'd3, 64'hCCCC, "R7");
    enq(1, 12'h408, 2'd0, 64'h5A, "R7");
    enq(0, 12'h409, 2'd0, '0, "R6");
    enq(1, 12'hFF8, 2'd3, 64'hDEAD_BEEF_0000_0001, "R7");
    enq(0, 12'hFF8, 2'd3, '0, "R4");
    drain();

    // R10: back-pressure holds the same result
    res_ready = 1'b0;
    enq(0, 12'h500, 2'd3, '0, "R10");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(res_valid == 1'b1, "R10", "held valid", res_valid, 1);
      check(res_age == age_ctr - 1'b1, "R10", "held age", res_age, age_ctr - 1'b1);
    end
    @(posedge clk); #1 res_ready = 1'b1;
    wait_empty();

    // R7: retire ignored while the head store is unchecked
    xlat_valid = 1'b0;
    enq(1, 12'h600, 2'd3, 64'h7777_8888, "R7");
    st_retire = 1'b1;
    repeat (3) @(posedge clk);
    #1 st_retire = 1'b0;
    enq(0, 12'h600, 2'd3, '0, "R7");
    xlat_valid = 1'b1;
    wait_empty();
    st_retire = 1'b1;
    @(posedge clk); #1 st_retire = 1'b0;
    live_q.delete();
    enq(0, 12'h600, 2'd3, '0, "R7");
    wait_empty();

    // R1: fill to depth without translation, extra offer refused
    xlat_valid = 1'b0;
    expect_on = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      enq(k[0], 12'h700, 2'd3, 64'h99, "R1");
    @(negedge clk);
    check(enq_ready == 1'b0, "R1", "full enq_ready", enq_ready, 0);
    check(res_valid == 1'b0, "R2", "no xlat res_valid", res_valid, 0);
    @(posedge clk); #1 enq_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(enq_ready == 1'b0, "R1", "still refused", enq_ready, 0);
    end
    @(posedge clk); #1 enq_valid = 1'b0;

    // R9: flush empties; flushed stores no longer forward
    flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R9", "res_valid after flush", res_valid, 0);
    check(enq_ready == 1'b1, "R9", "enq_ready after flush", enq_ready, 1);
    @(posedge clk); #1;
    expect_on = 1'b1;
    live_q.delete();
    xlat_valid = 1'b1;
    enq(0, 12'h700, 2'd3, '0, "R9");
    wait_empty();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule